// File: doc/BRIEF.md
# Dual-Bank Auto-Stepping RAM Address Unit

This block serves the operand memory of a DSP datapath. It holds two independent data RAM banks, each 256 words of 16 bits, and a private file of four 8-bit address pointers for each bank. An access names one pointer in a bank. The pointer's current value is the address for that access. At the end of the same cycle the pointer can move up or down by one. A loop that walks through a table therefore needs no separate address-update instruction.

The two banks work in parallel. In one cycle the datapath can address both banks and read one word from each. This supplies both operands of a multiply at once. Each bank also has a direct-load port that sets any of its pointers to a given value.

Top module: `dual_ptr_ram`

## Requirements
- R1: While reset is asserted, every pointer in both banks is cleared to 0, and the read data registers are cleared to 0.
- R2: Each bank's address output is the value of the pointer named by that bank's select input. It changes combinationally with the select and shows the value before any step of the current cycle.
- R3: An access (enable high) with step code 2'b01 increments the selected pointer at the clock edge that ends the access. The increment wraps from 255 to 0.
- R4: An access with step code 2'b10 decrements the selected pointer at the clock edge that ends the access. The decrement wraps from 0 to 255.
- R5: Step codes 2'b00 and 2'b11 leave the selected pointer unchanged. When enable is low, no pointer changes, whatever the step code.
- R6: A load sets the pointer named by the load select to the load value at the clock edge. If that pointer is also stepped in the same cycle, the load wins. A load of one pointer and a step of another pointer in the same cycle both take effect.
- R7: An access with write-enable high stores the write data at the current address and follows the same step rules as a read. With enable low, nothing is written.
- R8: An access with write-enable low puts the word at the current address on the read data output after the clock edge. Otherwise the read data output keeps its last value.
- R9: The two banks are independent. Both can be accessed in the same cycle, and each has its own pointers and its own storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Bank A access enable |
| a_we | input | 1 | Bank A write enable (with a_en) |
| a_sel | input | 2 | Bank A pointer select for the access |
| a_step | input | 2 | Bank A step code: 00 hold, 01 up, 10 down, 11 hold |
| a_wdata | input | 16 | Bank A write data |
| a_ld | input | 1 | Bank A pointer load strobe |
| a_ld_sel | input | 2 | Bank A pointer to load |
| a_ld_val | input | 8 | Bank A load value |
| a_addr | output | 8 | Bank A current address |
| a_rdata | output | 16 | Bank A registered read data |
| b_en | input | 1 | Bank B access enable |
| b_we | input | 1 | Bank B write enable (with b_en) |
| b_sel | input | 2 | Bank B pointer select for the access |
| b_step | input | 2 | Bank B step code: 00 hold, 01 up, 10 down, 11 hold |
| b_wdata | input | 16 | Bank B write data |
| b_ld | input | 1 | Bank B pointer load strobe |
| b_ld_sel | input | 2 | Bank B pointer to load |
| b_ld_val | input | 8 | Bank B load value |
| b_addr | output | 8 | Bank B current address |
| b_rdata | output | 16 | Bank B registered read data |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-bit pointers and four pointers per bank. With 8-bit pointers, starting a run at 254 or at 1 is enough to cross the wrap points in both step directions within three accesses. The small pointer file lets the bench load one pointer while another is stepped and then read back both. It can also confirm that a pointer never touched in one bank is unaffected by activity on the same pointer index in the other bank.

// File: rtl/dual_ptr_ram.sv
module dual_ptr_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NPTR   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_en,
  input  logic                    a_we,
  input  logic [$clog2(NPTR)-1:0] a_sel,
  input  logic [1:0]              a_step,
  input  logic [DATA_W-1:0]       a_wdata,
  input  logic                    a_ld,
  input  logic [$clog2(NPTR)-1:0] a_ld_sel,
  input  logic [ADDR_W-1:0]       a_ld_val,
  output logic [ADDR_W-1:0]       a_addr,
  output logic [DATA_W-1:0]       a_rdata,
  input  logic                    b_en,
  input  logic                    b_we,
  input  logic [$clog2(NPTR)-1:0] b_sel,
  input  logic [1:0]              b_step,
  input  logic [DATA_W-1:0]       b_wdata,
  input  logic                    b_ld,
  input  logic [$clog2(NPTR)-1:0] b_ld_sel,
  input  logic [ADDR_W-1:0]       b_ld_val,
  output logic [ADDR_W-1:0]       b_addr,
  output logic [DATA_W-1:0]       b_rdata
);

  localparam int SEL_W = $clog2(NPTR);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] STEP_UP = 2'b01;
  localparam logic [1:0] STEP_DN = 2'b10;

  logic              en   [2];
  logic              we   [2];
  logic [SEL_W-1:0]  sel  [2];
  logic [1:0]        step [2];
  logic [DATA_W-1:0] wdat [2];
  logic              ld   [2];
  logic [SEL_W-1:0]  lsel [2];
  logic [ADDR_W-1:0] lval [2];
  logic [ADDR_W-1:0] addr [2];
  logic [DATA_W-1:0] rdat [2];

  assign en[0]   = a_en;     assign en[1]   = b_en;
  assign we[0]   = a_we;     assign we[1]   = b_we;
  assign sel[0]  = a_sel;    assign sel[1]  = b_sel;
  assign step[0] = a_step;   assign step[1] = b_step;
  assign wdat[0] = a_wdata;  assign wdat[1] = b_wdata;
  assign ld[0]   = a_ld;     assign ld[1]   = b_ld;
  assign lsel[0] = a_ld_sel; assign lsel[1] = b_ld_sel;
  assign lval[0] = a_ld_val; assign lval[1] = b_ld_val;

  assign a_addr  = addr[0];
  assign b_addr  = addr[1];
  assign a_rdata = rdat[0];
  assign b_rdata = rdat[1];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [ADDR_W-1:0] ptr [NPTR];
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] nxt;

    assign addr[g] = ptr[sel[g]];

    always_comb begin
      case (step[g])
        STEP_UP: nxt = addr[g] + 1'b1;
        STEP_DN: nxt = addr[g] - 1'b1;
        default: nxt = addr[g];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int p = 0; p < NPTR; p++) ptr[p] <= '0;
      end else begin
        for (int p = 0; p < NPTR; p++) begin
          if (ld[g] && lsel[g] == SEL_W'(p))
            ptr[p] <= lval[g];
          else if (en[g] && sel[g] == SEL_W'(p))
            ptr[p] <= nxt;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (en[g] && we[g]) mem[addr[g]] <= wdat[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                 rdat[g] <= '0;
      else if (en[g] && !we[g])   rdat[g] <= mem[addr[g]];
    end
  end

endmodule

module dual_ptr_ram_chk #(
  parameter int ADDR_W = 8,
  parameter int NPTR   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    a_en,
  input logic [$clog2(NPTR)-1:0] a_sel,
  input logic [1:0]              a_step,
  input logic                    a_ld,
  input logic [$clog2(NPTR)-1:0] a_ld_sel,
  input logic [ADDR_W-1:0]       a_ld_val,
  input logic [ADDR_W-1:0]       a_addr,
  input logic                    b_en,
  input logic [$clog2(NPTR)-1:0] b_sel,
  input logic [1:0]              b_step,
  input logic                    b_ld,
  input logic [$clog2(NPTR)-1:0] b_ld_sel,
  input logic [ADDR_W-1:0]       b_ld_val,
  input logic [ADDR_W-1:0]       b_addr
);

  AST_A_RESET: assert property (@(posedge clk) !rst_n |=> a_addr == '0); // R1
  AST_B_RESET: assert property (@(posedge clk) !rst_n |=> b_addr == '0); // R1

  AST_A_INC: assert property (@(posedge clk) disable iff (!rst_n)
    a_en && a_step == 2'b01 && !(a_ld && a_ld_sel == a_sel)
    |=> (a_sel != $past(a_sel)) || (a_addr == ADDR_W'($past(a_addr) + 1'b1))); // R3
  AST_B_INC: assert property (@(posedge clk) disable iff (!rst_n)
    b_en && b_step == 2'b01 && !(b_ld && b_ld_sel == b_sel)
    |=> (b_sel != $past(b_sel)) || (b_addr == ADDR_W'($past(b_addr) + 1'b1))); // R3

  AST_A_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    a_en && a_step == 2'b10 && !(a_ld && a_ld_sel == a_sel)
    |=> (a_sel != $past(a_sel)) || (a_addr == ADDR_W'($past(a_addr) - 1'b1))); // R4
  AST_B_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    b_en && b_step == 2'b10 && !(b_ld && b_ld_sel == b_sel)
    |=> (b_sel != $past(b_sel)) || (b_addr == ADDR_W'($past(b_addr) - 1'b1))); // R4

  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_en || a_step == 2'b00 || a_step == 2'b11) && !(a_ld && a_ld_sel == a_sel)
    |=> (a_sel != $past(a_sel)) || $stable(a_addr)); // R5
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en || b_step == 2'b00 || b_step == 2'b11) && !(b_ld && b_ld_sel == b_sel)
    |=> (b_sel != $past(b_sel)) || $stable(b_addr)); // R5

  AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    a_ld |=> (a_sel != $past(a_ld_sel)) || (a_addr == $past(a_ld_val))); // R6
  AST_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    b_ld |=> (b_sel != $past(b_ld_sel)) || (b_addr == $past(b_ld_val))); // R6

endmodule

bind dual_ptr_ram dual_ptr_ram_chk #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_chk (.*);

// File: tb/dual_ptr_ram_bench.sv
module dual_ptr_ram_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic a_en = 0, a_we = 0, a_ld = 0;
  logic [1:0] a_sel = 0, a_step = 0, a_ld_sel = 0;
  logic [15:0] a_wdata = 0;
  logic [7:0] a_ld_val = 0, a_addr;
  logic [15:0] a_rdata;
  logic b_en = 0, b_we = 0, b_ld = 0;
  logic [1:0] b_sel = 0, b_step = 0, b_ld_sel = 0;
  logic [15:0] b_wdata = 0;
  logic [7:0] b_ld_val = 0, b_addr;
  logic [15:0] b_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_ptr_ram u_dual_ptr_ram (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    a_en = 0; a_we = 0; a_ld = 0; b_en = 0; b_we = 0; b_ld = 0;
  endtask

  task automatic load_a(input logic [1:0] p, input logic [7:0] v);
    a_ld = 1; a_ld_sel = p; a_ld_val = v; tick();
  endtask

  task automatic load_b(input logic [1:0] p, input logic [7:0] v);
    b_ld = 1; b_ld_sel = p; b_ld_val = v; tick();
  endtask

  task automatic t_reset();
    for (int p = 0; p < 4; p++) begin
      a_sel = 2'(p); b_sel = 2'(p); #1;
      chk(a_addr == 0, "R1 a ptr", a_addr, 0);
      chk(b_addr == 0, "R1 b ptr", b_addr, 0);
    end
    chk(a_rdata == 0 && b_rdata == 0, "R1 rdata", a_rdata, 0);
  endtask

  task automatic t_load();
    load_a(1, 10);
    a_sel = 1; #1;
    chk(a_addr == 10, "R2 load shows", a_addr, 10);
    a_en = 1; a_sel = 1; a_step = 2'b01; a_ld = 1; a_ld_sel = 1; a_ld_val = 50;
    #1 chk(a_addr == 10, "R2 pre-step addr", a_addr, 10);
    tick();
    chk(a_addr == 50, "R6 load priority", a_addr, 50);
    a_en = 1; a_sel = 1; a_step = 2'b01; a_ld = 1; a_ld_sel = 2; a_ld_val = 7;
    tick();
    chk(a_addr == 51, "R6 step other ptr", a_addr, 51);
    a_sel = 2; #1;
    chk(a_addr == 7, "R6 load other ptr", a_addr, 7);
  endtask

  task automatic t_inc_wrap();
    load_a(0, 254);
    a_sel = 0;
    for (int i = 0; i < 3; i++) begin
      a_en = 1; a_we = 1; a_step = 2'b01; a_wdata = 16'hA000 + 16'(i); tick();
    end
    chk(a_addr == 1, "R3 inc wrap", a_addr, 1);
    load_a(0, 254);
    for (int i = 0; i < 3; i++) begin
      a_en = 1; a_step = 2'b01; tick();
      chk(a_rdata == 16'hA000 + 16'(i), "R7 R8 read back", a_rdata, 16'hA000 + i);
    end
  endtask

  task automatic t_dec_wrap();
    load_b(3, 1);
    b_sel = 3;
    for (int i = 0; i < 3; i++) begin
      b_en = 1; b_we = 1; b_step = 2'b10; b_wdata = 16'hB000 + 16'(i); tick();
    end
    chk(b_addr == 254, "R4 dec wrap", b_addr, 254);
    load_b(3, 1);
    for (int i = 0; i < 3; i++) begin
      b_en = 1; b_step = 2'b10; tick();
      chk(b_rdata == 16'hB000 + 16'(i), "R4 R8 read back", b_rdata, 16'hB000 + i);
    end
  endtask

  task automatic t_hold();
    load_a(0, 0);
    a_sel = 0;
    a_en = 1; a_step = 2'b00; tick();
    chk(a_addr == 0, "R5 step 00", a_addr, 0);
    chk(a_rdata == 16'hA002, "R8 read at 0", a_rdata, 16'hA002);
    a_en = 1; a_step = 2'b11; tick();
    chk(a_addr == 0, "R5 step 11", a_addr, 0);
    a_en = 0; a_we = 1; a_step = 2'b01; a_wdata = 16'h5555;
    @(posedge clk); #1; a_we = 0;
    chk(a_addr == 0, "R5 no enable", a_addr, 0);
    chk(a_rdata == 16'hA002, "R8 rdata held", a_rdata, 16'hA002);
    a_en = 1; a_step = 2'b00; tick();
    chk(a_rdata == 16'hA002, "R7 no write w/o enable", a_rdata, 16'hA002);
  endtask

  task automatic t_dual();
    load_b(0, 255);
    a_sel = 0; b_sel = 0;
    a_en = 1; a_step = 2'b01; b_en = 1; b_step = 2'b10; tick();
    chk(a_rdata == 16'hA002, "R9 bank a operand", a_rdata, 16'hA002);
    chk(b_rdata == 16'hB002, "R9 bank b operand", b_rdata, 16'hB002);
    chk(a_addr == 1, "R9 a stepped", a_addr, 1);
    chk(b_addr == 254, "R9 b stepped", b_addr, 254);
    b_sel = 1; a_sel = 1; #1;
    chk(b_addr == 0, "R9 b ptr1 untouched", b_addr, 0);
    chk(a_addr == 51, "R9 a ptr1 kept", a_addr, 51);
    b_sel = 3; #1;
    chk(b_addr == 254, "R9 b ptr3 kept", b_addr, 254);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_load();
    t_inc_wrap();
    t_dec_wrap();
    t_hold();
    t_dual();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(CLK_PERIOD * 100000);
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule